// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block takes a freshly powered SD card from idle to 4-bit data transfer mode. It does this by driving a separate command engine through a fixed list of steps. For each step the sequencer presents four things: a command index, a 32-bit argument, a response kind and a data-read flag. The engine answers with a single done pulse, an error flag and up to 128 response bits. For a command that reads data, the engine returns the received bytes in the low 64 response bits, with the first byte received in bits [7:0].

The sequencer checks every answer and keeps the values the card reports: the operating-condition word, the identification block, the relative address, the card-specific data and the configuration register. It repeats the operating-condition request until the card reports ready, bounded by a timeout counted in clock cycles. Each step that needs the card address uses the stored one. When the card advertises 4-bit support, the sequencer switches the bus width and raises success. On any fault it stops and reports a failure code together with the number of the failing step.

Top module: `sd_init_seq`

## Requirements
- R1: Out of reset `busy`, `init_ok`, `init_fail`, `cmd_valid` and `wide_bus` are 0. A one-cycle `start` while idle sets `busy`, and the first command issued is index 0 with argument 0 and response kind none. Response kinds are encoded none=0, 48-bit=1, 48-bit with busy=2, 136-bit=3.
- R2: The second command is index 8 with argument 0x000001AA and a 48-bit response. If response bits [11:0] differ from 0x1AA, the run fails with code 2.
- R3: Every application command is preceded by index 55, sent with a 48-bit response and the argument {stored address, 16'h0000}. The stored address is 0 until index 3 has completed.
- R4: Index 41 is sent with argument 0x40FF8000 and a 48-bit response. The prefix and index 41 pair is repeated until response bit 31 is 1, and that response word [31:0] is then stored on `ocr`.
- R5: The loop of R4 is bounded by a cycle counter. The counter starts at the first prefix and its limit is CLK_HZ/1e6 × TIMEOUT_US cycles. A not-ready answer that arrives once the limit is reached fails the run with code 3 at step 3.
- R6: Index 2 (argument 0, 136-bit response) stores the full response on `cid`. Index 3 (argument 0, 48-bit response) stores response bits [31:16] on `rca`.
- R7: Index 9 with argument {rca, 16'h0} and a 136-bit response stores `csd`. The run fails with code 4 if bits [127:126] are not 2'b01, and otherwise with code 6 if bits [83:80] are not 9.
- R8: Index 7 is sent with argument {rca, 16'h0} and response kind 48-bit with busy.
- R9: Index 51 is sent with argument 0xAAAAAAAA, a 48-bit response and the data flag set. The received byte k (response bits [8k+7:8k]) is stored in `scr` bits [8(7-k)+7:8(7-k)].
- R10: If `scr` bit 50 is 1, index 6 is sent with argument 2 and a 48-bit response, and its completion raises `wide_bus` and `init_ok`. If the bit is 0, the run fails with code 5 at step 9.
- R11: An engine error fails the run with code 1. Steps are numbered 0 (index 0), 1 (index 8), 2 (prefix), 3 (index 41), 4 (index 2), 5 (index 3), 6 (index 9), 7 (index 7), 8 (prefix), 9 (index 51), 10 (prefix) and 11 (index 6). The failing step appears on `fail_step`, `busy` drops, and no further command is issued.
- R12: `start` has no effect while `busy` is 1. A `start` after completion clears `init_ok`, `init_fail` and `wide_bus` and runs the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| busy | output | 1 | Sequence in progress |
| init_ok | output | 1 | Card reached 4-bit transfer mode |
| init_fail | output | 1 | Sequence stopped on a fault |
| fail_code | output | 3 | Fault kind (see requirements) |
| fail_step | output | 4 | Step number at which the fault occurred |
| cmd_valid | output | 1 | One-cycle request to the engine |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp | output | 2 | Expected response kind |
| cmd_data | output | 1 | Command reads a data block |
| eng_done | input | 1 | Engine finished the current command |
| eng_err | input | 1 | Engine reports a failure with done |
| eng_rsp | input | 128 | Response bits, or read data in [63:0] |
| rca | output | 16 | Stored relative card address |
| ocr | output | 32 | Stored operating-condition word |
| cid | output | 128 | Stored identification block |
| csd | output | 128 | Stored card-specific data |
| scr | output | 64 | Stored configuration register |
| wide_bus | output | 1 | Host data width set to 4 bits |

## Verification
The assertions check several rules on every cycle:
- a request is only made while busy;
- every prefix request carries a zero low half-word and a 48-bit response kind;
- the interface-condition request always carries its fixed pattern;
- success and failure are never raised together, and success implies the wide bus;
- a failed run issues nothing further;
- once the timeout counter expires, it stays expired.

Only the bench's scenarios can show the rest:
- the exact order of commands and their arguments;
- the address carried forward from index 3;
- the byte reversal of the configuration register;
- the pairing of each fault with its code and step;
- the retry loop running out of time.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [1:0] {
        RSP_NONE    = 2'd0,
        RSP_48      = 2'd1,
        RSP_48_BUSY = 2'd2,
        RSP_136     = 2'd3
    } rsp_kind_e;

    typedef enum logic [3:0] {
        ST_RESET_CARD = 4'd0,
        ST_IF_COND    = 4'd1,
        ST_OPC_PFX    = 4'd2,
        ST_OPC        = 4'd3,
        ST_GET_ID     = 4'd4,
        ST_GET_ADDR   = 4'd5,
        ST_GET_SPEC   = 4'd6,
        ST_SELECT     = 4'd7,
        ST_CFG_PFX    = 4'd8,
        ST_CFG        = 4'd9,
        ST_WIDE_PFX   = 4'd10,
        ST_WIDE       = 4'd11
    } step_e;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_ENGINE   = 3'd1,
        FC_ECHO     = 3'd2,
        FC_TIMEOUT  = 3'd3,
        FC_SPEC_VER = 3'd4,
        FC_NO_WIDE  = 3'd5,
        FC_BLK_LEN  = 3'd6
    } fail_e;

    localparam logic [31:0] IF_COND_ARG = 32'h0000_01AA;
    localparam logic [31:0] OPC_ARG     = 32'h40FF_8000;
    localparam logic [31:0] CFG_ARG     = 32'hAAAA_AAAA;
    localparam logic [31:0] WIDE_ARG    = 32'h0000_0002;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        rsp_kind_e   kind;
        logic        data;
    } cmd_t;

    function automatic cmd_t step_cmd(input step_e s, input logic [15:0] addr);
        cmd_t c;
        c = '{idx: 6'd0, arg: 32'd0, kind: RSP_48, data: 1'b0};
        case (s)
            ST_RESET_CARD: c.kind = RSP_NONE;
            ST_IF_COND:    begin c.idx = 6'd8;  c.arg = IF_COND_ARG; end
            ST_OPC_PFX, ST_CFG_PFX, ST_WIDE_PFX:
                           begin c.idx = 6'd55; c.arg = {addr, 16'h0000}; end
            ST_OPC:        begin c.idx = 6'd41; c.arg = OPC_ARG; end
            ST_GET_ID:     begin c.idx = 6'd2;  c.kind = RSP_136; end
            ST_GET_ADDR:   c.idx = 6'd3;
            ST_GET_SPEC:   begin c.idx = 6'd9;  c.arg = {addr, 16'h0000}; c.kind = RSP_136; end
            ST_SELECT:     begin c.idx = 6'd7;  c.arg = {addr, 16'h0000}; c.kind = RSP_48_BUSY; end
            ST_CFG:        begin c.idx = 6'd51; c.arg = CFG_ARG; c.data = 1'b1; end
            ST_WIDE:       begin c.idx = 6'd6;  c.arg = WIDE_ARG; end
            default:       c.kind = RSP_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [63:0] flip_bytes(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) begin
            r[8*(7-k) +: 8] = v[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/sd_init_timer.sv
module sd_init_timer #(
    parameter longint LIMIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q >= LIM);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: once reached, the limit stays reached until cleared
    p_expiry_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (expired && !clear) |=> expired);

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int TIMEOUT_US = 500_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         busy,
    output logic         init_ok,
    output logic         init_fail,
    output logic [2:0]   fail_code,
    output logic [3:0]   fail_step,
    output logic         cmd_valid,
    output logic [5:0]   cmd_index,
    output logic [31:0]  cmd_arg,
    output logic [1:0]   cmd_rsp,
    output logic         cmd_data,
    input  logic         eng_done,
    input  logic         eng_err,
    input  logic [127:0] eng_rsp,
    output logic [15:0]  rca,
    output logic [31:0]  ocr,
    output logic [127:0] cid,
    output logic [127:0] csd,
    output logic [63:0]  scr,
    output logic         wide_bus
);
    localparam longint TIMEOUT_CYC = (longint'(CLK_HZ) / 64'd1_000_000) * longint'(TIMEOUT_US);
    localparam longint LIMIT_CYC   = (TIMEOUT_CYC < 1) ? 1 : TIMEOUT_CYC;

    step_e       step_q, nx_step;
    logic        busy_q, issue_q, ok_q, fail_q, wide_q;
    fail_e       code_q, fail_kind;
    logic [3:0]  fstep_q;
    logic [15:0] rca_q;
    logic [31:0] ocr_q;
    logic [127:0] cid_q, csd_q;
    logic [63:0] scr_q, scr_in;
    logic        fail_now, finish_now, expired;
    cmd_t        cur;

    sd_init_timer #(.LIMIT(LIMIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (!busy_q),
        .run     (busy_q && (step_q == ST_OPC_PFX || step_q == ST_OPC)),
        .expired (expired)
    );

    assign cur    = step_cmd(step_q, rca_q);
    assign scr_in = flip_bytes(eng_rsp[63:0]);

    always_comb begin
        nx_step    = step_q;
        fail_now   = 1'b0;
        fail_kind  = FC_NONE;
        finish_now = 1'b0;
        if (eng_err) begin
            fail_now  = 1'b1;
            fail_kind = FC_ENGINE;
        end else begin
            case (step_q)
                ST_RESET_CARD: nx_step = ST_IF_COND;
                ST_IF_COND:
                    if (eng_rsp[11:0] != IF_COND_ARG[11:0]) begin
                        fail_now = 1'b1; fail_kind = FC_ECHO;
                    end else nx_step = ST_OPC_PFX;
                ST_OPC_PFX:  nx_step = ST_OPC;
                ST_OPC:
                    if (eng_rsp[31])  nx_step = ST_GET_ID;
                    else if (expired) begin fail_now = 1'b1; fail_kind = FC_TIMEOUT; end
                    else              nx_step = ST_OPC_PFX;
                ST_GET_ID:   nx_step = ST_GET_ADDR;
                ST_GET_ADDR: nx_step = ST_GET_SPEC;
                ST_GET_SPEC:
                    if (eng_rsp[127:126] != 2'b01) begin
                        fail_now = 1'b1; fail_kind = FC_SPEC_VER;
                    end else if (eng_rsp[83:80] != 4'd9) begin
                        fail_now = 1'b1; fail_kind = FC_BLK_LEN;
                    end else nx_step = ST_SELECT;
                ST_SELECT:   nx_step = ST_CFG_PFX;
                ST_CFG_PFX:  nx_step = ST_CFG;
                ST_CFG:
                    if (!scr_in[50]) begin fail_now = 1'b1; fail_kind = FC_NO_WIDE; end
                    else nx_step = ST_WIDE_PFX;
                ST_WIDE_PFX: nx_step = ST_WIDE;
                ST_WIDE:     finish_now = 1'b1;
                default:     begin fail_now = 1'b1; fail_kind = FC_ENGINE; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_RESET_CARD;
            busy_q  <= 1'b0;
            issue_q <= 1'b0;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
            wide_q  <= 1'b0;
            code_q  <= FC_NONE;
            fstep_q <= '0;
            rca_q   <= '0;
            ocr_q   <= '0;
            cid_q   <= '0;
            csd_q   <= '0;
            scr_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                issue_q <= 1'b1;
                step_q  <= ST_RESET_CARD;
                ok_q    <= 1'b0;
                fail_q  <= 1'b0;
                wide_q  <= 1'b0;
                code_q  <= FC_NONE;
                fstep_q <= '0;
                rca_q   <= '0;
            end
        end else if (issue_q) begin
            issue_q <= 1'b0;
        end else if (eng_done) begin
            if (!eng_err) begin
                case (step_q)
                    ST_OPC:      if (eng_rsp[31]) ocr_q <= eng_rsp[31:0];
                    ST_GET_ID:   cid_q <= eng_rsp;
                    ST_GET_ADDR: rca_q <= eng_rsp[31:16];
                    ST_GET_SPEC: csd_q <= eng_rsp;
                    ST_CFG:      scr_q <= scr_in;
                    default: ;
                endcase
            end
            if (fail_now) begin
                busy_q  <= 1'b0;
                fail_q  <= 1'b1;
                code_q  <= fail_kind;
                fstep_q <= step_q;
            end else if (finish_now) begin
                busy_q <= 1'b0;
                ok_q   <= 1'b1;
                wide_q <= 1'b1;
            end else begin
                step_q  <= nx_step;
                issue_q <= 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign init_ok   = ok_q;
    assign init_fail = fail_q;
    assign fail_code = code_q;
    assign fail_step = fstep_q;
    assign cmd_valid = busy_q && issue_q;
    assign cmd_index = cur.idx;
    assign cmd_arg   = cur.arg;
    assign cmd_rsp   = cur.kind;
    assign cmd_data  = cur.data;
    assign rca       = rca_q;
    assign ocr       = ocr_q;
    assign cid       = cid_q;
    assign csd       = csd_q;
    assign scr       = scr_q;
    assign wide_bus  = wide_q;

    // R11: requests only while a sequence runs
    p_req_in_run_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
    // R3: prefix carries the address in the upper half and a 48-bit response
    p_prefix_form_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_index == 6'd55) |-> (cmd_arg[15:0] == 16'h0 && cmd_rsp == 2'd1));
    // R2: interface-condition request carries voltage field and pattern
    p_if_cond_arg_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_index == 6'd8) |-> (cmd_arg == 32'h0000_01AA));
    // R10: success implies wide bus and excludes failure
    p_ok_is_wide_r10: assert property (@(posedge clk) disable iff (rst)
        init_ok |-> (wide_bus && !init_fail));
    // R11: a failed run issues nothing further
    p_fail_halts_r11: assert property (@(posedge clk) disable iff (rst)
        (init_fail && !start) |=> !cmd_valid);

endmodule

// File: tb/tb_sd_init_seq.sv
`timescale 1ns/1ps
module tb_sd_init_seq;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, init_ok, init_fail, cmd_valid, cmd_data, wide_bus;
    logic [2:0] fail_code;
    logic [3:0] fail_step;
    logic [5:0] cmd_index;
    logic [31:0] cmd_arg, ocr;
    logic [1:0] cmd_rsp;
    logic eng_done = 1'b0, eng_err = 1'b0;
    logic [127:0] eng_rsp = '0, cid, csd;
    logic [15:0] rca;
    logic [63:0] scr;

    always #2.5 clk = ~clk;

    sd_init_seq #(.CLK_HZ(200_000_000), .TIMEOUT_US(2)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .init_ok(init_ok),
        .init_fail(init_fail), .fail_code(fail_code), .fail_step(fail_step),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_rsp(cmd_rsp), .cmd_data(cmd_data), .eng_done(eng_done),
        .eng_err(eng_err), .eng_rsp(eng_rsp), .rca(rca), .ocr(ocr),
        .cid(cid), .csd(csd), .scr(scr), .wide_bus(wide_bus)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    localparam logic [127:0] CID_C = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [15:0]  RCA_C = 16'hB37A;

    function automatic logic [127:0] csd_of(input logic [1:0] ver, input logic [3:0] blk);
        logic [127:0] v;
        v = 128'h0;
        v[127:126] = ver;
        v[83:80]   = blk;
        v[71:62]   = 10'h3A5;
        return v;
    endfunction

    // engine model state
    int cur_busy = 0, cur_err = -1, ocr_seen = 0, log_n = 0;
    bit cur_echo = 1, cur_scr4 = 1;
    logic [1:0] cur_ver = 2'b01;
    logic [3:0] cur_blk = 4'd9;
    logic [5:0]  lg_idx [64];
    logic [31:0] lg_arg [64];
    logic [1:0]  lg_rsp [64];
    logic        lg_dat [64];

    initial begin : engine
        bit pend, perr;
        int cnt;
        logic [5:0] pidx;
        pend = 0; perr = 0; cnt = 0; pidx = 0;
        forever begin
            @(posedge clk); #1;
            eng_done = 1'b0;
            eng_err  = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    pend = 0;
                    eng_done = 1'b1;
                    eng_err  = perr;
                    case (pidx)
                        6'd8:  eng_rsp = cur_echo ? 128'h1AA : 128'h1A5;
                        6'd41: if (ocr_seen < cur_busy) begin
                                   eng_rsp = 128'h00FF_8000; ocr_seen++;
                               end else eng_rsp = 128'hC0FF_8000;
                        6'd2:  eng_rsp = CID_C;
                        6'd3:  eng_rsp = {96'h0, RCA_C, 16'h0500};
                        6'd9:  eng_rsp = csd_of(cur_ver, cur_blk);
                        6'd51: eng_rsp = {64'h0, 8'h44, 8'h33, 8'h22, 8'h11, 8'h00, 8'h80,
                                          (cur_scr4 ? 8'h05 : 8'h01), 8'h02};
                        default: eng_rsp = 128'h900;
                    endcase
                end else cnt--;
            end
            if (cmd_valid) begin
                if (log_n < 64) begin
                    lg_idx[log_n] = cmd_index; lg_arg[log_n] = cmd_arg;
                    lg_rsp[log_n] = cmd_rsp;   lg_dat[log_n] = cmd_data;
                end
                perr = (log_n == cur_err);
                log_n++;
                pidx = cmd_index; pend = 1; cnt = 1;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while (busy && w < 20000) begin
            @(posedge clk); #1; w++;
        end
        if (w >= 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not end actual=busy expected=idle");
        end
    endtask

    task automatic setup(input int b, input bit e, input logic [1:0] v,
                         input logic [3:0] bl, input bit s4, input int er);
        cur_busy = b; cur_echo = e; cur_ver = v; cur_blk = bl;
        cur_scr4 = s4; cur_err = er; ocr_seen = 0; log_n = 0;
    endtask

    typedef struct packed {
        int         busy_n;
        bit         echo;
        bit [1:0]   ver;
        bit [3:0]   blk;
        bit         scr4;
        int         err_seq;
        bit         exp_ok;
        bit [2:0]   code;
        bit [3:0]   stp;
        int         exp_n;
    } scn_t;

    localparam scn_t TBL [0:10] = '{
        '{2,    1'b1, 2'b01, 4'd9,  1'b1, -1, 1'b1, 3'd0, 4'd0, 16},
        '{0,    1'b1, 2'b01, 4'd9,  1'b1, -1, 1'b1, 3'd0, 4'd0, 12},
        '{2,    1'b0, 2'b01, 4'd9,  1'b1, -1, 1'b0, 3'd2, 4'd1, 2},
        '{2,    1'b1, 2'b00, 4'd9,  1'b1, -1, 1'b0, 3'd4, 4'd6, 11},
        '{2,    1'b1, 2'b01, 4'd10, 1'b1, -1, 1'b0, 3'd6, 4'd6, 11},
        '{2,    1'b1, 2'b01, 4'd9,  1'b0, -1, 1'b0, 3'd5, 4'd9, 14},
        '{2,    1'b1, 2'b01, 4'd9,  1'b1, 0,  1'b0, 3'd1, 4'd0, 1},
        '{2,    1'b1, 2'b01, 4'd9,  1'b1, 5,  1'b0, 3'd1, 4'd3, 6},
        '{2,    1'b1, 2'b01, 4'd9,  1'b1, 9,  1'b0, 3'd1, 4'd5, 10},
        '{2,    1'b1, 2'b01, 4'd9,  1'b1, 13, 1'b0, 3'd1, 4'd9, 14},
        '{1000, 1'b1, 2'b01, 4'd9,  1'b1, -1, 1'b0, 3'd3, 4'd3, -1}
    };

    localparam logic [5:0] E_IDX [0:15] = '{0,8,55,41,55,41,55,41,2,3,9,7,55,51,55,6};
    localparam logic [1:0] E_RSP [0:15] = '{0,1,1,1,1,1,1,1,3,1,3,2,1,1,1,1};

    function automatic logic [31:0] e_arg(input int k);
        case (k)
            1: return 32'h0000_01AA;
            3, 5, 7: return 32'h40FF_8000;
            10, 11, 12, 14: return {RCA_C, 16'h0};
            13: return 32'hAAAA_AAAA;
            15: return 32'h2;
            default: return 32'h0;
        endcase
    endfunction

    initial begin : watchdog
        #(5ns * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "ok after reset", init_ok, 0);
        chk("R1", "fail after reset", init_fail, 0);
        chk("R1", "cmd_valid after reset", cmd_valid, 0);
        chk("R1", "wide_bus after reset", wide_bus, 0);

        // table of scenarios (R2 R5 R7 R10 R11)
        for (int i = 0; i < 11; i++) begin
            setup(TBL[i].busy_n, TBL[i].echo, TBL[i].ver, TBL[i].blk, TBL[i].scr4, TBL[i].err_seq);
            pulse_start();
            chk("R1", $sformatf("busy after start s%0d", i), busy, 1);
            wait_idle();
            chk("R10", $sformatf("init_ok s%0d", i), init_ok, TBL[i].exp_ok);
            chk("R11", $sformatf("init_fail s%0d", i), init_fail, !TBL[i].exp_ok);
            chk("R11", $sformatf("fail_code s%0d", i), fail_code, TBL[i].code);
            if (!TBL[i].exp_ok)
                chk("R11", $sformatf("fail_step s%0d", i), fail_step, TBL[i].stp);
            if (TBL[i].exp_n >= 0)
                chk("R11", $sformatf("command count s%0d", i), log_n, TBL[i].exp_n);
            repeat (4) @(posedge clk); #1;
            if (TBL[i].exp_n >= 0)
                chk("R11", $sformatf("no command after end s%0d", i), log_n, TBL[i].exp_n);
        end

        // directed: full sequence with two not-ready answers; start pulsed mid-run (R12)
        setup(2, 1, 2'b01, 4'd9, 1, -1);
        pulse_start();
        repeat (10) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_idle();
        chk("R12", "start while busy ignored: count", log_n, 16);
        for (int k = 0; k < 16; k++) begin
            chk("R3", $sformatf("index of cmd %0d", k), lg_idx[k], E_IDX[k]);
            chk("R4", $sformatf("arg of cmd %0d", k), lg_arg[k], e_arg(k));
            chk("R8", $sformatf("rsp kind of cmd %0d", k), lg_rsp[k], E_RSP[k]);
            chk("R9", $sformatf("data flag of cmd %0d", k), lg_dat[k], (k == 13));
        end
        chk("R4", "ocr stored", ocr, 32'hC0FF_8000);
        chk("R6", "cid stored", cid, CID_C);
        chk("R6", "rca stored", rca, RCA_C);
        chk("R7", "csd stored", csd, csd_of(2'b01, 4'd9));
        chk("R9", "scr byte order", scr, 64'h0205_8000_1122_3344);
        chk("R10", "wide_bus set", wide_bus, 1);

        // R12 restart clears flags
        setup(0, 1, 2'b01, 4'd9, 1, -1);
        pulse_start();
        chk("R12", "wide_bus cleared on restart", wide_bus, 0);
        chk("R12", "init_ok cleared on restart", init_ok, 0);
        wait_idle();
        chk("R12", "restart completes", init_ok, 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule